// File: doc/BRIEF.md
# Serialized SAFER+ Round Datapath

This block computes one SAFER+ encryption round on a 128-bit state. A round mixes a key into the state twice, once before and once after an octet-wise nonlinear layer, then diffuses the result across all sixteen octets with a linear network. To keep the nonlinear layer small, the block processes one 16-bit slice (two octets) per clock. Eight clocks are needed for the whole state, and a single exponent table and a single logarithm table are shared by every slice.

A higher-level sequencer raises `start` for one cycle with the round input and the two round subkeys present. The block latches all three, walks through the eight slices, then runs the registered result through the pseudo-Hadamard and shuffle network into an output register. It pulses `done` for one cycle when that register has been loaded. The output register holds its value until the next round completes. Key scheduling and the chaining of several rounds sit outside this block.

Top module: `safer_round_serial`

## Requirements
- R1: While `rst` is high at a clock edge, `round_out` becomes all zeros and `done` becomes 0.
- R2: Octets are numbered 0 to 15, with octet 0 at bits 127:120. Octets 0, 3, 4, 7, 8, 11, 12 and 15 pass through the exponent path: y = (E(x XOR k1) + k2) mod 256, where E(v) = (45^v mod 257) mod 256, so E(128) = 0.
- R3: Octets 1, 2, 5, 6, 9, 10, 13 and 14 pass through the logarithm path: y = L((x + k1) mod 256) XOR k2. L is the inverse of E, so L(0) = 128.
- R4: The nonlinear result goes through four layers of 2-point transforms, with (a, b) mapped to ((2a + b) mod 256, (a + b) mod 256) on octet pairs (0,1), (2,3) and so on. After each of the first three layers the octets are shuffled with out[i] = in[P[i]], where P = 8,11,12,15,2,1,6,5,10,9,14,13,0,7,4,3. The fourth layer's result is `round_out`.
- R5: `done` is high for exactly one cycle. It rises 9 clock edges after the edge at which `start` was accepted, and no other `done` appears in between.
- R6: `round_in`, `sub_k1` and `sub_k2` are sampled only at the edge where `start` is accepted. Changes to them later in the round do not affect the result.
- R7: A `start` raised while a round is in progress is ignored. It produces no extra `done`, and the result is that of the round already running.
- R8: `round_out` keeps its value in every cycle in which `done` is low.
- R9: The nonlinear layer handles octets 2s and 2s+1 at step s, for s = 0 to 7. The exponent table serves the even octet on even steps and the odd octet on odd steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a round; accepted only when idle |
| round_in | input | 128 | Round input state, octet 0 in the top byte |
| sub_k1 | input | 128 | Subkey applied before the tables |
| sub_k2 | input | 128 | Subkey applied after the tables |
| round_out | output | 128 | Registered round result |
| done | output | 1 | One-cycle pulse when round_out is updated |

## Verification
The hardest entries to reach are the table values at the edges of the range: exponent input 128, which yields 0, and logarithm input 0, which yields 128. Random data reaches them only by chance, because each table input is a combination of data and key. The stimulus therefore derives the first subkey from the chosen state, so that every exponent octet sees 128 and every logarithm octet sees 0 at its table. A second hard case is a start request in the middle of a round, together with input changes after acceptance. The bench drives both and expects exactly one result, the one for the originally latched operands.

// File: rtl/safer_rnd_pkg.sv
package safer_rnd_pkg;
  localparam int OCT_W   = 8;
  localparam int N_OCT   = 16;
  localparam int STATE_W = OCT_W * N_OCT;
  localparam int STEPS   = N_OCT / 2;
  localparam int STEP_W  = $clog2(STEPS);
  localparam int TBL_N   = 1 << OCT_W;
  localparam int N_LAYER = 4;

  typedef logic [OCT_W-1:0] oct_t;
  typedef oct_t [0:N_OCT-1] blk_t;   // element 0 sits in the top byte

  typedef enum logic [3:0] {
    ST_S0 = 4'd0, ST_S1 = 4'd1, ST_S2 = 4'd2, ST_S3 = 4'd3,
    ST_S4 = 4'd4, ST_S5 = 4'd5, ST_S6 = 4'd6, ST_S7 = 4'd7,
    ST_IDLE = 4'd8, ST_FIN = 4'd9
  } st_t;

  // (45^v mod 257) mod 256
  function automatic oct_t pow45(input int v);
    int p;
    p = 1;
    for (int i = 0; i < TBL_N; i++) begin
      if (i < v) p = (p * 45) % 257;
    end
    return oct_t'(p % 256);
  endfunction

  // inverse of pow45
  function automatic oct_t lg45(input int v);
    int p;
    int r;
    p = 1;
    r = 0;
    for (int e = 0; e < TBL_N; e++) begin
      if ((p % 256) == v) r = e;
      p = (p * 45) % 257;
    end
    return oct_t'(r);
  endfunction

  function automatic int shuf(input int i);
    case (i)
      0: return 8;   1: return 11;  2: return 12;  3: return 15;
      4: return 2;   5: return 1;   6: return 6;   7: return 5;
      8: return 10;  9: return 9;   10: return 14; 11: return 13;
      12: return 0;  13: return 7;  14: return 4;  default: return 3;
    endcase
  endfunction
endpackage

// File: rtl/safer_nl_lane.sv
module safer_nl_lane
  import safer_rnd_pkg::*;
(
  input  logic [STEP_W-1:0] step,
  input  oct_t              xa,
  input  oct_t              xb,
  input  oct_t              ka1,
  input  oct_t              kb1,
  input  oct_t              ka2,
  input  oct_t              kb2,
  output oct_t              ya,
  output oct_t              yb
);
  oct_t exp_tbl [TBL_N];
  oct_t log_tbl [TBL_N];

  for (genvar i = 0; i < TBL_N; i++) begin : g_tbl
    assign exp_tbl[i] = pow45(i);
    assign log_tbl[i] = lg45(i);
  end

  logic odd;
  oct_t exp_idx, log_idx, exp_val, log_val;

  assign odd     = step[0];
  assign exp_idx = odd ? (xb ^ kb1) : (xa ^ ka1);
  assign log_idx = odd ? oct_t'(xa + ka1) : oct_t'(xb + kb1);
  assign exp_val = exp_tbl[exp_idx];
  assign log_val = log_tbl[log_idx];
  assign ya      = odd ? (log_val ^ ka2) : oct_t'(exp_val + ka2);
  assign yb      = odd ? oct_t'(exp_val + kb2) : (log_val ^ kb2);
endmodule

// File: rtl/safer_mix.sv
module safer_mix
  import safer_rnd_pkg::*;
(
  input  blk_t d,
  output blk_t q
);
  blk_t lay_in  [N_LAYER];
  blk_t lay_out [N_LAYER];

  always_comb begin
    lay_in[0] = d;
    for (int l = 0; l < N_LAYER; l++) begin
      for (int j = 0; j < N_OCT / 2; j++) begin
        lay_out[l][2*j]   = oct_t'(2 * lay_in[l][2*j] + lay_in[l][2*j+1]);
        lay_out[l][2*j+1] = oct_t'(lay_in[l][2*j] + lay_in[l][2*j+1]);
      end
      if (l < N_LAYER - 1) begin
        for (int i = 0; i < N_OCT; i++) lay_in[l+1][i] = lay_out[l][shuf(i)];
      end
    end
    q = lay_out[N_LAYER-1];
  end
endmodule

// File: rtl/safer_rnd_ctl.sv
module safer_rnd_ctl
  import safer_rnd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              cap,
  output logic              nl_we,
  output logic [STEP_W-1:0] step,
  output logic              fin
);
  st_t st;

  assign cap   = (st == ST_IDLE) && start;
  assign nl_we = !st[3];
  assign step  = st[STEP_W-1:0];
  assign fin   = (st == ST_FIN);

  always_ff @(posedge clk) begin
    if (rst) st <= ST_IDLE;
    else begin
      case (st)
        ST_IDLE: if (start) st <= ST_S0;
        ST_S7:   st <= ST_FIN;
        ST_FIN:  st <= ST_IDLE;
        default: st <= st_t'(st + 4'd1);
      endcase
    end
  end
endmodule

// File: rtl/safer_round_serial.sv
module safer_round_serial
  import safer_rnd_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [STATE_W-1:0] round_in,
  input  logic [STATE_W-1:0] sub_k1,
  input  logic [STATE_W-1:0] sub_k2,
  output logic [STATE_W-1:0] round_out,
  output logic               done
);
  blk_t x_q, k1_q, k2_q, nl_q, mixed;
  logic cap, nl_we, fin;
  logic [STEP_W-1:0] step;
  oct_t ya, yb;

  safer_rnd_ctl u_ctl (
    .clk(clk), .rst(rst), .start(start),
    .cap(cap), .nl_we(nl_we), .step(step), .fin(fin)
  );

  safer_nl_lane u_lane (
    .step(step),
    .xa(x_q[{step, 1'b0}]),  .xb(x_q[{step, 1'b1}]),
    .ka1(k1_q[{step, 1'b0}]), .kb1(k1_q[{step, 1'b1}]),
    .ka2(k2_q[{step, 1'b0}]), .kb2(k2_q[{step, 1'b1}]),
    .ya(ya), .yb(yb)
  );

  safer_mix u_mix (.d(nl_q), .q(mixed));

  always_ff @(posedge clk) begin
    if (cap) begin
      x_q  <= round_in;
      k1_q <= sub_k1;
      k2_q <= sub_k2;
    end
    if (nl_we) begin
      nl_q[{step, 1'b0}] <= ya;
      nl_q[{step, 1'b1}] <= yb;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      round_out <= '0;
      done      <= 1'b0;
    end else begin
      done <= fin;
      if (fin) round_out <= mixed;
    end
  end
endmodule

// File: rtl/safer_round_chk.sv
module safer_round_chk
  import safer_rnd_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               start,
  input logic               done,
  input logic [STATE_W-1:0] round_out
);
  logic       busy;
  logic [3:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (!busy) begin
      busy <= start;
      cnt  <= '0;
    end else if (done) begin
      busy <= start;
      cnt  <= '0;
    end else begin
      cnt <= cnt + 4'd1;
    end
  end

  p_done_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_latency_r5: assert property (@(posedge clk) disable iff (rst)
    done |-> (busy && cnt == 4'd9));

  p_no_stray_done_r7: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !done);

  p_hold_out_r8: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(round_out));
endmodule

bind safer_round_serial safer_round_chk u_chk (
  .clk(clk), .rst(rst), .start(start), .done(done), .round_out(round_out)
);

// File: tb/sim_safer_round_serial.sv
module sim_safer_round_serial;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [127:0] round_in = '0, sub_k1 = '0, sub_k2 = '0;
  logic [127:0] round_out;
  logic done;

  int total = 0;
  int bad = 0;
  int et [256];
  int lt [256];
  logic [127:0] expq [$];

  always #5 clk = ~clk;

  safer_round_serial u0 (
    .clk(clk), .rst(rst), .start(start), .round_in(round_in),
    .sub_k1(sub_k1), .sub_k2(sub_k2), .round_out(round_out), .done(done)
  );

  function automatic logic [127:0] ref_round(logic [127:0] x, logic [127:0] a, logic [127:0] b);
    int s [16];
    int t [16];
    logic [127:0] r;
    for (int i = 0; i < 16; i++) begin
      int xv, av, bv;
      xv = x[127-8*i -: 8]; av = a[127-8*i -: 8]; bv = b[127-8*i -: 8];
      if (i % 4 == 0 || i % 4 == 3) s[i] = (et[xv ^ av] + bv) % 256;  // R2
      else s[i] = lt[(xv + av) % 256] ^ bv;                           // R3
    end
    for (int l = 0; l < 4; l++) begin                                  // R4
      for (int j = 0; j < 8; j++) begin
        t[2*j]   = (2 * s[2*j] + s[2*j+1]) % 256;
        t[2*j+1] = (s[2*j] + s[2*j+1]) % 256;
      end
      if (l < 3) begin
        int pm [16] = '{8, 11, 12, 15, 2, 1, 6, 5, 10, 9, 14, 13, 0, 7, 4, 3};
        for (int i = 0; i < 16; i++) s[i] = t[pm[i]];
      end
    end
    for (int i = 0; i < 16; i++) r[127-8*i -: 8] = t[i][7:0];          // R9 octet order
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp_v);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
    end
  endtask

  // monitor: scoreboard pop on every done
  logic [127:0] last_res = '0;
  always @(negedge clk) begin
    if (!rst && done) begin
      if (expq.size() == 0) chk(1'b0, "R7 unexpected done", round_out, '0);
      else begin
        logic [127:0] e;
        e = expq.pop_front();
        chk(round_out === e, "R2 R3 R4 R6 R9 round result", round_out, e);
        last_res = e;
      end
    end else if (!rst && expq.size() != 0) begin
      chk(round_out === last_res, "R8 output hold", round_out, last_res);
    end
  end

  // mode 0 plain, 1 scramble inputs after start, 2 extra start mid-round
  task automatic run(input logic [127:0] x, input logic [127:0] a, input logic [127:0] b, input int mode);
    int k;
    @(negedge clk);
    round_in = x; sub_k1 = a; sub_k2 = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    expq.push_back(ref_round(x, a, b));
    if (mode == 1) begin round_in = ~x; sub_k1 = ~a; sub_k2 = x ^ b; end  // R6
    k = 0;
    do begin
      if (mode == 2 && k == 3) begin start = 1'b1; round_in = ~x; sub_k1 = b; end  // R7
      @(negedge clk);
      start = 1'b0;
      k++;
    end while (!done && k < 30);
    chk(k == 9, "R5 latency", 128'(k), 128'd9);
    @(negedge clk);
    chk(done === 1'b0, "R5 single-cycle pulse", 128'(done), 128'd0);
    if (mode == 2) begin
      int extra;
      extra = 0;
      for (int i = 0; i < 12; i++) begin
        @(negedge clk);
        if (done) extra++;
      end
      chk(extra == 0, "R7 ignored start", 128'(extra), 128'd0);
    end
  endtask

  initial begin
    int p;
    p = 1;
    for (int e = 0; e < 256; e++) begin
      et[e] = p % 256;
      lt[p % 256] = e;
      p = (p * 45) % 257;
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [127:0] x, a;
    repeat (3) @(negedge clk);
    chk(round_out === '0, "R1 reset output", round_out, '0);
    chk(done === 1'b0, "R1 reset done", 128'(done), '0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(done === 1'b0 && round_out === '0, "R1 after reset", round_out, '0);

    run('0, '0, '0, 0);
    run('1, '1, '1, 0);
    run(128'h000102030405060708090a0b0c0d0e0f, 128'h0f0e0d0c0b0a09080706050403020100,
        128'h00112233445566778899aabbccddeeff, 0);
    for (int n = 0; n < 4; n++)
      run({$urandom, $urandom, $urandom, $urandom}, {$urandom, $urandom, $urandom, $urandom},
          {$urandom, $urandom, $urandom, $urandom}, 0);

    // table edges: exp input 128 (R2), log input 0 (R3)
    x = {$urandom, $urandom, $urandom, $urandom};
    for (int i = 0; i < 16; i++) begin
      if (i % 4 == 0 || i % 4 == 3) a[127-8*i -: 8] = x[127-8*i -: 8] ^ 8'h80;
      else a[127-8*i -: 8] = 8'(-x[127-8*i -: 8]);
    end
    run(x, a, '0, 0);
    run(x, a, {$urandom, $urandom, $urandom, $urandom}, 0);

    run({$urandom, $urandom, $urandom, $urandom}, {$urandom, $urandom, $urandom, $urandom},
        128'h5a5a5a5a5a5a5a5a5a5a5a5a5a5a5a5a, 1);
    run({$urandom, $urandom, $urandom, $urandom}, 128'h0123456789abcdef0123456789abcdef,
        {$urandom, $urandom, $urandom, $urandom}, 2);

    repeat (3) @(negedge clk);
    chk(expq.size() == 0, "R7 scoreboard drained", 128'(expq.size()), '0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule